// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM device from power-on to normal operation. After a one-cycle start pulse it captures three configuration values: a group word whose width bit marks a 16-bit data bus, a timing word that holds the CAS latency and a two-bit refresh mode, and an optional preset mode value. It then issues a fixed series of commands, one valid strobe per command. First comes a single NOP. After a power-on wait of at least 200 microseconds it issues one PRECHARGE, eight AUTO REFRESH commands and one MODE REGISTER SET. At least 80 ns separate any two commands in that list.

While the sequence runs, the block presents the captured timing word with its refresh field forced to zero, so that the refresh engine downstream stays idle. Once the sequence is over, the full word is passed through and a done flag rises. All pins are plain control and status signals. Nothing here streams data, so the block has no valid/ready handshake and no back-pressure. Waits are counted in clock cycles, derived from the CLK_MHZ parameter and rounded up.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is low, cmd_valid is 0, cmd_word is 0x00, done is 0 and timing_out is 0.
- R2: A start pulse sampled in the idle state captures grp_cfg, timing_cfg and preset_word. In the following cycle it produces one strobe with cmd_word equal to the NOP code 0x00, with no payload added.
- R3: From reset until done rises, timing_out equals the captured timing word with bits [7:6] (the refresh field) cleared.
- R4: The PRECHARGE strobe comes exactly W = 200*CLK_MHZ cycles after the NOP strobe.
- R5: After the PRECHARGE, exactly 8 REFRESH strobes follow and then one MODE REGISTER SET strobe. Consecutive strobes in this list are G cycles apart, where G = max(2, ceil(80*CLK_MHZ/1000)).
- R6: When the preset value is zero, the payload is computed from the timing word and the group word. A CAS latency of 2 in timing word bits [2:0] gives 0x40, and any other latency gives 0x60. When bit 9 of the group word is set, that value is halved (0x20 or 0x30).
- R7: Every list strobe carries cmd_word = payload OR command code. The codes are PRECHARGE 0x1, REFRESH 0x2 and MODE REGISTER SET 0x3.
- R8: A nonzero preset_word replaces the computed payload.
- R9: Done rises G cycles after the MODE REGISTER SET strobe. In that same cycle timing_out becomes the full captured timing word. Done then stays high until reset, and no strobe follows it.
- R10: A start pulse while the sequence runs, or after done, has no effect on any output.
- R11: cmd_valid is high for one cycle per command. In every cycle without a strobe, cmd_word is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin the sequence |
| grp_cfg | input | 32 | Group configuration; bit 9 set means a 16-bit bus |
| timing_cfg | input | 32 | Timing word; bits [2:0] CAS latency, bits [7:6] refresh mode |
| preset_word | input | 8 | Preset mode payload; zero selects the computed one |
| cmd_word | output | 8 | Command word (code in low bits, payload ORed in) |
| cmd_valid | output | 1 | One-cycle strobe per issued command |
| timing_out | output | 32 | Timing word to the refresh engine, refresh field gated |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
Every result is due at a fixed cycle offset from the clock edge that samples start. The NOP strobe is due one cycle later. List command i (counting from 0) is due 1+W+i*G cycles later. Done and the restored timing word are due 1+W+10*G cycles later. The bench's reference model counts cycles from that edge, computes each expected output from these offsets and the payload rule, and compares all four outputs at every falling edge. An odd clock rate is used so that the gap has to be rounded up. Extra start pulses are sent mid-wait, mid-list and after done, with different configuration values.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PWR  = 2'd1,
    ST_LIST = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam logic [3:0] CODE_NOP = 4'h0;
  localparam logic [3:0] CODE_PRE = 4'h1;
  localparam logic [3:0] CODE_REF = 4'h2;
  localparam logic [3:0] CODE_MRS = 4'h3;
endpackage

// File: rtl/pwrup_payload.sv
module pwrup_payload #(
  parameter int CFG_W     = 32,
  parameter int CMD_W     = 8,
  parameter int WIDTH_BIT = 9,
  parameter int CL_LSB    = 0,
  parameter int CL_W      = 3
) (
  input  logic [CFG_W-1:0] grp_cfg,
  input  logic [CFG_W-1:0] timing_cfg,
  input  logic [CMD_W-1:0] preset_word,
  output logic [CMD_W-1:0] payload
);
  logic [CL_W-1:0]  cas_lat;
  logic [CMD_W-1:0] base;

  always_comb begin
    cas_lat = timing_cfg[CL_LSB +: CL_W];
    base    = (cas_lat == CL_W'(2)) ? CMD_W'(8'h40) : CMD_W'(8'h60);
    if (grp_cfg[WIDTH_BIT]) base = base >> 1;
    payload = (preset_word != '0) ? preset_word : base;
  end
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign zero = (cnt == '0);

  assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import sdram_pwrup_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int NUM_REF  = 8,
  parameter int TW       = 8,
  parameter int WAIT_CYC = 100,
  parameter int GAP_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_zero,
  input  logic [CMD_W-1:0] payload,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             latch_en,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_valid,
  output logic             done
);
  localparam int LIST_LEN = NUM_REF + 2;
  localparam int IW       = $clog2(LIST_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(LIST_LEN - 1);
  localparam logic [TW-1:0] WAIT_LD  = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] GAP_LD   = TW'(GAP_CYC - 1);

  seq_state_t       state, nstate;
  logic [IW-1:0]    idx, nidx;
  logic             issue;
  logic [CMD_W-1:0] issue_word;

  function automatic logic [CMD_W-1:0] list_word(input logic [IW-1:0] i,
                                                 input logic [CMD_W-1:0] p);
    logic [3:0] code;
    if (i == '0)            code = CODE_PRE;
    else if (i == LAST_IDX) code = CODE_MRS;
    else                    code = CODE_REF;
    return p | CMD_W'(code);
  endfunction

  always_comb begin
    nstate     = state;
    nidx       = idx;
    issue      = 1'b0;
    issue_word = CMD_W'(CODE_NOP);
    tmr_load   = 1'b0;
    tmr_val    = '0;
    latch_en   = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        latch_en = 1'b1;
        issue    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = WAIT_LD;
        nstate   = ST_PWR;
      end
      ST_PWR: if (tmr_zero) begin
        issue      = 1'b1;
        issue_word = list_word('0, payload);
        tmr_load   = 1'b1;
        tmr_val    = GAP_LD;
        nidx       = '0;
        nstate     = ST_LIST;
      end
      ST_LIST: if (tmr_zero) begin
        if (idx == LAST_IDX) begin
          nstate = ST_DONE;
        end else begin
          issue      = 1'b1;
          issue_word = list_word(idx + IW'(1), payload);
          tmr_load   = 1'b1;
          tmr_val    = GAP_LD;
          nidx       = idx + IW'(1);
        end
      end
      default: nstate = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= CMD_W'(CODE_NOP);
    end else begin
      state     <= nstate;
      idx       <= nidx;
      cmd_valid <= issue;
      cmd_word  <= issue ? issue_word : CMD_W'(CODE_NOP);
    end
  end

  assign done = (state == ST_DONE);

  // Checker counter: strobes issued since reset.
  logic [7:0] pulse_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse_cnt <= '0;
    else if (cmd_valid) pulse_cnt <= pulse_cnt + 8'd1;
  end

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_no_cmd_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_list_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (pulse_cnt == 8'(LIST_LEN + 1)));
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_pwrup_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int CFG_W     = 32,
  parameter int CMD_W     = 8,
  parameter int NUM_REF   = 8,
  parameter int WIDTH_BIT = 9,
  parameter int CL_LSB    = 0,
  parameter int CL_W      = 3,
  parameter int REF_LSB   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] grp_cfg,
  input  logic [CFG_W-1:0] timing_cfg,
  input  logic [CMD_W-1:0] preset_word,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_valid,
  output logic [CFG_W-1:0] timing_out,
  output logic             done
);
  localparam int WAIT_CYC = 200 * CLK_MHZ;
  localparam int GAP_RAW  = (80 * CLK_MHZ + 999) / 1000;
  localparam int GAP_CYC  = (GAP_RAW < 2) ? 2 : GAP_RAW;
  localparam int TW       = $clog2(WAIT_CYC + 1);
  localparam logic [CFG_W-1:0] REF_MASK = CFG_W'(3) << REF_LSB;

  logic [CMD_W-1:0] pay_live, pay_q;
  logic [CFG_W-1:0] timing_q;
  logic             tmr_load, tmr_zero, latch_en;
  logic [TW-1:0]    tmr_val;

  pwrup_payload #(
    .CFG_W(CFG_W), .CMD_W(CMD_W), .WIDTH_BIT(WIDTH_BIT),
    .CL_LSB(CL_LSB), .CL_W(CL_W)
  ) u_payload (
    .grp_cfg(grp_cfg), .timing_cfg(timing_cfg),
    .preset_word(preset_word), .payload(pay_live)
  );

  pwrup_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_val(tmr_val), .zero(tmr_zero)
  );

  pwrup_fsm #(
    .CMD_W(CMD_W), .NUM_REF(NUM_REF), .TW(TW),
    .WAIT_CYC(WAIT_CYC), .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_zero(tmr_zero),
    .payload(pay_q), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .latch_en(latch_en), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q    <= '0;
      timing_q <= '0;
    end else if (latch_en) begin
      pay_q    <= pay_live;
      timing_q <= timing_cfg;
    end
  end

  assign timing_out = done ? timing_q : (timing_q & ~REF_MASK);

  assert_capture_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || cmd_valid) |=> $stable(timing_q));
endmodule

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BENCH_MHZ  = 30;
  localparam int W_EXP      = 200 * BENCH_MHZ;
  localparam int G_RAW      = (80 * BENCH_MHZ + 999) / 1000;
  localparam int G_EXP      = (G_RAW < 2) ? 2 : G_RAW;
  localparam int N_LIST     = 10;
  localparam logic [31:0] REF_FIELD = 32'h0000_00C0;

  logic        clk, rst_n, start;
  logic [31:0] grp_cfg, timing_cfg, timing_out;
  logic [7:0]  preset_word, cmd_word;
  logic        cmd_valid, done;

  sdram_pwrup_seq #(.CLK_MHZ(BENCH_MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .grp_cfg(grp_cfg),
    .timing_cfg(timing_cfg), .preset_word(preset_word),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .timing_out(timing_out), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    compared = 0, mism = 0, cyc = 0;
  bit    finished = 0;
  bit    m_active = 0;
  int    m_c = 0;
  logic [31:0] m_t = '0;
  logic [7:0]  m_pay = '0;
  string scen_tag = "R1";

  function automatic logic [7:0] calc_pay(logic [31:0] g, logic [31:0] t, logic [7:0] p);
    logic [7:0] b;
    if (p != 0) return p;                      // R8
    b = (t[2:0] == 3'd2) ? 8'h40 : 8'h60;       // R6
    if (g[9]) b = b >> 1;
    return b;
  endfunction

  function automatic logic [7:0] list_code(int i);
    if (i == 0) return 8'h01;
    if (i == N_LIST - 1) return 8'h03;
    return 8'h02;
  endfunction

  // Reference model: cycles since the edge that accepted start.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_c = 0; m_t = '0; m_pay = '0;
    end else if (m_active) begin
      m_c++;
    end else if (start) begin
      m_active = 1; m_c = 1;
      m_t   = timing_cfg;
      m_pay = calc_pay(grp_cfg, timing_cfg, preset_word);
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic        e_valid, e_done;
      logic [7:0]  e_word;
      logic [31:0] e_t;
      string       vreq;
      int          li;
      li = -1;
      e_valid = 0; e_word = 8'h00; e_done = 0; e_t = '0; vreq = "R11";
      if (!rst_n) begin
        vreq = "R1";
      end else if (m_active) begin
        for (int i = 0; i < N_LIST; i++)
          if (m_c == 1 + W_EXP + i * G_EXP) li = i;
        if (m_c == 1) begin
          e_valid = 1; vreq = "R2";
        end else if (li >= 0) begin
          e_valid = 1;
          e_word  = list_code(li) | m_pay;
          vreq    = (li == 0) ? "R4" : "R5";
        end
        e_done = (m_c >= 1 + W_EXP + N_LIST * G_EXP);
        e_t    = e_done ? m_t : (m_t & ~REF_FIELD);
      end
      chk(vreq, "cmd_valid", 32'(cmd_valid), 32'(e_valid));
      // R7 payload OR code; scen_tag names R6/R8/R10 scenario
      chk((li >= 0) ? {"R7/", scen_tag} : vreq, "cmd_word", 32'(cmd_word), 32'(e_word));
      chk(rst_n ? "R9" : "R1", "done", 32'(done), 32'(e_done));
      chk(rst_n ? "R3" : "R1", "timing_out", timing_out, e_t);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    wait_cyc(1);
    start = 1'b0;
  endtask

  task automatic run(logic [31:0] g, logic [31:0] t, logic [7:0] p, string tag, bit pokes);
    scen_tag = tag;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    grp_cfg = g; timing_cfg = t; preset_word = p;
    wait_cyc(2);
    pulse_start();
    if (pokes) begin
      // R10: starts during the wait and during the list, other config
      wait_cyc(100);
      grp_cfg = 32'h0; timing_cfg = 32'h0000_00C5; preset_word = 8'h11;
      pulse_start();
      wait_cyc(W_EXP - 100);
      pulse_start();
      wait_cyc(N_LIST * G_EXP + 20);
    end else begin
      wait_cyc(W_EXP + N_LIST * G_EXP + 20);
    end
    // R10: start after done
    grp_cfg = 32'h200; timing_cfg = 32'h0000_0003; preset_word = 8'h00;
    pulse_start();
    wait_cyc(20);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      compared++; mism++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    grp_cfg = '0; timing_cfg = '0; preset_word = '0;
    wait_cyc(4);
    run(32'h0000_0000, 32'h0000_12C2, 8'h00, "R6", 0); // CL2, 32-bit -> 0x40
    run(32'h0000_0200, 32'h0000_0043, 8'h00, "R6", 0); // CL3, 16-bit -> 0x30
    run(32'h0000_0205, 32'h0000_0082, 8'h00, "R10", 1); // CL2, 16-bit -> 0x20
    run(32'h0000_0000, 32'h0000_00C5, 8'h00, "R6", 0); // CL5, 32-bit -> 0x60
    run(32'h0000_0200, 32'h0000_00C2, 8'h90, "R8", 0); // preset wins
    finish_up();
  end
endmodule